// File: doc/BRIEF.md
# Sample-History ADC Correction Table

This block cleans up a single converter's output stream using the sample just taken and the sample taken before it. Each valid input code is kept in a one-sample history register. The present code and the stored previous code together address a writable table of signed correction values. The correction read for that pair is added to the present code. The result is clamped to the legal code range and leaves the block with a valid flag, two cycles after the sample came in.

The table is loaded per converter through a simple write port, at any time, with values found by calibrating that converter. Reset empties the history and sets every table entry to zero, so the block passes samples through unchanged until calibration data is written. Because the correction depends on where the signal was one sample earlier, as well as on its present level, a second converter is not needed to find the signal's direction of travel.

Top module: `adc_hist_corrector`

## Requirements
- R1: `out_valid` is high in cycle t+2 exactly when `in_valid` was high in cycle t. At no other time is it high.
- R2: The table address is `{present code, previous code}`, with the present code in the upper W bits and the previous code in the lower W bits. The entry at that address is added to the present code only.
- R3: For the first valid sample after reset, the previous code is taken as zero.
- R4: The history register advances only on cycles where `in_valid` is high. Codes presented while `in_valid` is low do not change the history.
- R5: Sample codes are unsigned, from 0 to 2^W-1, and corrections are two's complement values C bits wide. A sum above 2^W-1 is output as 2^W-1.
- R6: A sum below zero is output as 0.
- R7: Reset sets every table entry to zero. After reset, each sample comes out equal to its input until new entries are written.
- R8: Writes are accepted in any cycle. A sample presented in the same cycle as a write to its address uses the old entry. Samples presented in later cycles use the new entry.
- R9: `out_code` is zero after reset and keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new converter sample is present |
| in_code | input | W | Unsigned converter code |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 2W | Table address, {present, previous} |
| wr_data | input | C | Signed correction value |
| out_valid | output | 1 | Corrected sample is present |
| out_code | output | W | Corrected, clamped code |

## Verification
With an empty table, a stream that covers zero, full scale and values in between shows whether the block is transparent before calibration. Sending the same present code twice after different previous codes separates a lookup that uses the history from one that uses only the present level. The first sample after reset shows whether the history starts at zero. Invalid cycles carrying unrelated codes show whether the history is guarded by the valid flag. Large positive and negative entries exercise both clamps. A write issued in the same cycle as a sample that reads it fixes the read-before-write ordering.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    // Outcome of the final add, used to pick the output code
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_kind_e;

    // Width of an intermediate sum that holds code plus correction without wrapping
    function automatic int unsigned sum_width(input int unsigned code_w, input int unsigned corr_w);
        return ((code_w > corr_w) ? code_w : corr_w) + 2;
    endfunction

endpackage

// File: rtl/adc_hist_addr.sv
module adc_hist_addr #(
    parameter int unsigned W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_code,
    output logic [W-1:0]   prev_code,
    output logic [2*W-1:0] rd_addr
);
    // History register: follows only valid samples, starts from code zero
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_code <= '0;
        end else if (in_valid) begin
            prev_code <= in_code;
        end
    end

    assign rd_addr = {in_code, prev_code};
endmodule

// File: rtl/adc_corr_mem.sv
module adc_corr_mem #(
    parameter int unsigned AW = 12,
    parameter int unsigned C  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [C-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [C-1:0]  wr_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [C-1:0] table_q [DEPTH];

    // Registered read: a write in the same cycle is not seen by that read
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                table_q[i] <= '0;
            end
            rd_data <= '0;
        end else begin
            rd_data <= table_q[rd_addr];
            if (wr_en) begin
                table_q[wr_addr] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/adc_sat_add.sv
module adc_sat_add
    import adc_corr_pkg::*;
#(
    parameter int unsigned W = 6,
    parameter int unsigned C = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s1_valid,
    input  logic [W-1:0] s1_code,
    input  logic [C-1:0] corr,
    output logic         out_valid,
    output logic [W-1:0] out_code
);
    localparam int unsigned SW = sum_width(W, C);
    localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << W) - 1);

    logic signed [SW-1:0] code_ext;
    logic signed [SW-1:0] corr_ext;
    logic signed [SW-1:0] sum;
    sat_kind_e            kind;
    logic [W-1:0]         result;

    assign code_ext = $signed({{(SW-W){1'b0}}, s1_code});
    assign corr_ext = $signed({{(SW-C){corr[C-1]}}, corr});
    assign sum      = code_ext + corr_ext;

    always_comb begin
        if (sum < 0) begin
            kind = SAT_LOW;
        end else if (sum > CODE_MAX) begin
            kind = SAT_HIGH;
        end else begin
            kind = SAT_NONE;
        end
    end

    always_comb begin
        unique case (kind)
            SAT_LOW:  result = '0;
            SAT_HIGH: result = '1;
            default:  result = sum[W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_code <= result;
            end
        end
    end
endmodule

// File: rtl/adc_hist_corrector.sv
module adc_hist_corrector #(
    parameter int unsigned W = 6,
    parameter int unsigned C = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_code,
    input  logic           wr_en,
    input  logic [2*W-1:0] wr_addr,
    input  logic [C-1:0]   wr_data,
    output logic           out_valid,
    output logic [W-1:0]   out_code
);
    localparam int unsigned AW = 2 * W;

    logic [W-1:0]  prev_code;
    logic [AW-1:0] rd_addr;
    logic [C-1:0]  rd_corr;
    logic          s1_valid;
    logic [W-1:0]  s1_code;

    adc_hist_addr #(.W(W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .prev_code (prev_code),
        .rd_addr   (rd_addr)
    );

    adc_corr_mem #(.AW(AW), .C(C)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .rd_data (rd_corr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Present code travels alongside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_code  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_code <= in_code;
            end
        end
    end

    adc_sat_add #(.W(W), .C(C)) u_add (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_code   (s1_code),
        .corr      (rd_corr),
        .out_valid (out_valid),
        .out_code  (out_code)
    );
endmodule

// File: rtl/adc_hist_corrector_chk.sv
module adc_hist_corrector_chk #(
    parameter int unsigned W = 6,
    parameter int unsigned C = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_code,
    input logic [W-1:0] prev_code,
    input logic         s1_valid,
    input logic [W-1:0] s1_code,
    input logic [C-1:0] rd_corr
);
    logic         v1, v2;
    logic [W-1:0] ck_code;
    logic         ck_neg;
    logic         ck_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1      <= 1'b0;
            v2      <= 1'b0;
            ck_code <= '0;
            ck_neg  <= 1'b0;
            ck_zero <= 1'b1;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (s1_valid) begin
                ck_code <= s1_code;
                ck_neg  <= rd_corr[C-1];
                ck_zero <= (rd_corr == '0);
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid == v2); // R1
    AST_HIST_GUARD:    assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(prev_code)); // R4
    AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (rst) (out_valid && !ck_neg) |-> out_code >= ck_code); // R5
    AST_NO_UNDERFLOW:  assert property (@(posedge clk) disable iff (rst) (out_valid && ck_neg) |-> out_code <= ck_code); // R6
    AST_ZERO_PASS:     assert property (@(posedge clk) disable iff (rst) (out_valid && ck_zero) |-> out_code == ck_code); // R7
    AST_HOLD_IDLE:     assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_code)); // R9
endmodule

bind adc_hist_corrector adc_hist_corrector_chk #(.W(W), .C(C)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_code  (out_code),
    .prev_code (prev_code),
    .s1_valid  (s1_valid),
    .s1_code   (s1_code),
    .rd_corr   (rd_corr)
);

// File: tb/sim_adc_hist_corrector.sv
module sim_adc_hist_corrector;
    localparam int W = 6;
    localparam int C = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_code = '0;
    logic           wr_en = 1'b0;
    logic [2*W-1:0] wr_addr = '0;
    logic [C-1:0]   wr_data = '0;
    logic           out_valid;
    logic [W-1:0]   out_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_hist_corrector #(.W(W), .C(C)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_entry(input int present, input int previous, input int corr);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {present[W-1:0], previous[W-1:0]}; wr_data = corr[C-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One isolated sample: checks latency, value and hold afterwards
    task automatic send_one(input int code, input int exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_code = code[W-1:0];
        @(negedge clk);
        in_valid = 1'b0; in_code = 7;
        check("R1 early", int'(out_valid), 0);
        @(negedge clk);
        check("R1 on time", int'(out_valid), 1);
        check(req, int'(out_code), exp);
        @(negedge clk);
        check("R1 single", int'(out_valid), 0);
        check("R9 hold", int'(out_code), exp);
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R9 reset valid", int'(out_valid), 0);
        check("R9 reset code", int'(out_code), 0);
    endtask

    // Empty table: back-to-back stream passes unchanged, R7
    task automatic test_passthrough();
        int codes [4] = '{10, 0, 63, 37};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 stream valid", int'(out_valid), 1);
                check("R7 passthrough", int'(out_code), codes[i-2]);
            end
            in_valid = (i < 4);
            in_code  = (i < 4) ? codes[i][W-1:0] : 6'd5;
        end
        @(negedge clk);
        check("R1 stream end", int'(out_valid), 0);
    endtask

    task automatic test_history();
        do_reset();
        write_entry(20, 0, 4);
        write_entry(20, 20, -3);
        send_one(20, 24, "R3 first sample prev zero");
        send_one(20, 17, "R2 present/previous pair");
        repeat (5) begin
            @(negedge clk);
            in_code = 33;
        end
        write_entry(33, 20, 6);
        send_one(33, 39, "R4 gap keeps history");
    endtask

    task automatic test_saturation();
        write_entry(60, 33, 10);
        send_one(60, 63, "R5 clamp high");
        write_entry(3, 60, -9);
        send_one(3, 0, "R6 clamp low");
    endtask

    task automatic test_write_order();
        // prev is 3; write {12,3} in the same cycle the sample 12 is presented
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {6'd12, 6'd3}; wr_data = 5'd5;
        in_valid = 1'b1; in_code = 12;
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R8 same-cycle old entry", int'(out_code), 12);
        send_one(3, 3, "R8 neutral step");
        send_one(12, 17, "R8 later sample new entry");
    endtask

    task automatic test_reset_clears();
        do_reset();
        send_one(20, 20, "R7 table cleared by reset");
    endtask

    initial begin
        test_reset_state();
        test_passthrough();
        test_history();
        test_saturation();
        test_write_order();
        test_reset_clears();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule